// File: doc/BRIEF.md
# Steerable Expiry Timer

The block is a periodic down-counting timer on a small 32-bit register bus. Software sets a reload value, starts the counter and gets a sticky pending flag each time the count runs out. The counter reloads itself on every expiry, so the flag repeats with a fixed period. A write-one action register clears the flag or restarts the count. A separate action bit does each job.

The flag is gated by an interrupt enable and then steered to exactly one of eight destinations. These are the normal-priority or the fast-priority interrupt line of one of four cores. A 3-bit routing code picks the destination. Unmapped addresses read as zero and ignore writes. Reads have no side effects.

Top module: `expiry_timer`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0, the routing code reads 0, the internal count is 0 and all eight interrupt outputs are low.
- R2: The control word at offset 0x0 has these fields: reload value in bits 27:0, run bit 28, interrupt enable bit 29. Bit 30 always reads 0. Bit 31 reads the pending flag and is read-only, so writes to bits 30 and 31 change nothing. Any address other than 0x0, 0x4 and 0x8 reads 0 and ignores writes.
- R3: On every clock with run = 1, a count above 1 decrements by one. A count of 0 or 1 is an expiry instead: the pending flag is set and the count is loaded with the reload value. A reload value R ≥ 1 therefore expires once every R clocks, and R = 0 expires on every clock.
- R4: With run = 0 the count is frozen and no expiry happens. Setting run again continues from the frozen count.
- R5: The action word at offset 0x4 works as follows. Writing 1 to bit 30 loads the count from the reload value. Writing 1 to bit 31 clears the pending flag. Other bits are ignored, the word always reads 0, and the pending flag otherwise holds its value.
- R6: If a clear write and an expiry fall in the same clock, the pending flag ends up 1.
- R7: An expiry sets the pending flag even when the interrupt enable is 0. A destination is driven high only while both the pending flag and the enable are 1.
- R8: The routing word at offset 0x8 holds a code in bits 2:0, and bits 31:3 read 0. Codes 0 to 3 select the normal line of core 0 to 3 (`core_irq[n]`). Codes 4 to 7 select the fast line of core code−4 (`core_fiq[n]`). At most one of the eight outputs is ever high.
- R9: Rewriting the routing code while the interrupt is active moves the asserted output to the new destination in the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_irq | output | 4 | Normal-priority interrupt, one bit per core |
| core_fiq | output | 4 | Fast-priority interrupt, one bit per core |

## Verification
A behavioural model in the bench follows the timer clock by clock and compares the read data and all eight outputs after every edge.

Several stimulus patterns are used, each to separate a particular pair of behaviours:
- A reload of 5 with no interference shows the period and the self-reload.
- A reload of 0 separates the "expire on one or zero" rule from a plain decrement.
- A string of back-to-back clear writes lands one clear on an expiry clock, which separates the expiry-wins rule from clear-wins.
- Stopping and restarting the timer shows the count is frozen rather than reloaded.
- Sweeping all eight routing codes with junk in the upper bits, while masking and unmasking the enable, separates the pending flag from the routed outputs.

// File: rtl/expiry_timer_pkg.sv
// Package: shared constants of the steerable expiry timer.
// Assumes a 32-bit register bus with byte offsets.
package expiry_timer_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OFS_CTRL = 0;
    localparam int unsigned OFS_ACT  = 4;
    localparam int unsigned OFS_RT   = 8;
    localparam int unsigned PEND_BIT = 31;  // read-only flag in control word
    localparam int unsigned LOAD_BIT = 30;  // action word: restart count
    localparam int unsigned CLR_BIT  = 31;  // action word: clear pending
endpackage

// File: rtl/expiry_timer_regs.sv
// Module: register file of the timer.
// Decodes the control, action and routing words, holds the control fields
// and routing code, turns action writes into one-clock pulses and muxes
// the read data. Assumes RELOAD_W <= 29 so that the run and enable bits
// fit below the pending bit.
module expiry_timer_regs
    import expiry_timer_pkg::*;
#(
    parameter int unsigned RELOAD_W = 28,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CODE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                pend,
    output logic [RELOAD_W-1:0] reload_q,
    output logic                run_q,
    output logic                irq_en_q,
    output logic [CODE_W-1:0]   route_q,
    output logic                load_pulse,
    output logic                clr_pulse
);
    localparam int unsigned RUN_BIT = RELOAD_W;
    localparam int unsigned IE_BIT  = RELOAD_W + 1;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(OFS_ACT);
    localparam logic [ADDR_W-1:0] A_RT   = ADDR_W'(OFS_RT);

    logic sel_ctrl, sel_act, sel_rt;

    // Address decode.
    always_comb begin
        sel_ctrl = (bus_addr == A_CTRL);
        sel_act  = (bus_addr == A_ACT);
        sel_rt   = (bus_addr == A_RT);
    end

    // Control word storage: reload value, run and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            run_q    <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (bus_we && sel_ctrl) begin
            reload_q <= bus_wdata[RELOAD_W-1:0];
            run_q    <= bus_wdata[RUN_BIT];
            irq_en_q <= bus_wdata[IE_BIT];
        end
    end

    // Routing code storage; upper write bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= '0;
        else if (bus_we && sel_rt)
            route_q <= bus_wdata[CODE_W-1:0];
    end

    // Action word: write-one bits become single-clock pulses.
    always_comb begin
        load_pulse = bus_we && sel_act && bus_wdata[LOAD_BIT];
        clr_pulse  = bus_we && sel_act && bus_wdata[CLR_BIT];
    end

    // Read mux; the action word and unmapped offsets read as zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[RELOAD_W-1:0] = reload_q;
            bus_rdata[RUN_BIT]      = run_q;
            bus_rdata[IE_BIT]       = irq_en_q;
            bus_rdata[PEND_BIT]     = pend;
        end else if (sel_rt) begin
            bus_rdata[CODE_W-1:0] = route_q;
        end
    end
endmodule

// File: rtl/expiry_timer_core.sv
// Module: down-counter and sticky pending flag.
// While running, a count of 0 or 1 is an expiry. An expiry sets the flag
// and reloads the count; otherwise the count steps down by one. A load
// pulse reloads the count at any time. A clear pulse drops the flag
// unless an expiry lands in the same clock.
module expiry_timer_core #(
    parameter int unsigned RELOAD_W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                load_pulse,
    input  logic                clr_pulse,
    output logic [RELOAD_W-1:0] cnt_q,
    output logic                expire,
    output logic                pend_q
);
    // Expiry detect: the next step would reach zero, or the count already sits there.
    always_comb expire = run && (cnt_q <= RELOAD_W'(1));

    // Count register: reload on expiry or load pulse, else decrement while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (expire || load_pulse)
            cnt_q <= reload;
        else if (run)
            cnt_q <= cnt_q - RELOAD_W'(1);
    end

    // Pending flag: set by expiry, which has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (expire)
            pend_q <= 1'b1;
        else if (clr_pulse)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/expiry_timer_steer.sv
// Module: output steering.
// The top code bit picks the fast line over the normal line, and the
// lower bits pick the core. Assumes NUM_CORES is a power of two, >= 2.
module expiry_timer_steer #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned CODE_W    = 3
) (
    input  logic                 pend,
    input  logic                 irq_en,
    input  logic [CODE_W-1:0]    route,
    output logic [NUM_CORES-1:0] core_irq,
    output logic [NUM_CORES-1:0] core_fiq
);
    localparam int unsigned CORE_W = CODE_W - 1;

    logic fire;
    logic use_fast;

    // Gate the flag with the enable and split the code.
    always_comb begin
        fire     = pend && irq_en;
        use_fast = route[CODE_W-1];
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic hit;
        // Per-core match of the core field.
        always_comb hit = fire && (route[CORE_W-1:0] == CORE_W'(g));
        assign core_irq[g] = hit && !use_fast;
        assign core_fiq[g] = hit && use_fast;
    end
endmodule

// File: rtl/expiry_timer.sv
// Module: top of the steerable expiry timer.
// Joins the register file, the counter and the steering. Assumes a single
// clock domain and one bus access per clock.
module expiry_timer
    import expiry_timer_pkg::*;
#(
    parameter int unsigned RELOAD_W  = 28,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] core_irq,
    output logic [NUM_CORES-1:0] core_fiq
);
    localparam int unsigned CORE_W = $clog2(NUM_CORES);
    localparam int unsigned CODE_W = CORE_W + 1;

    logic [RELOAD_W-1:0] reload_q;
    logic                run_q;
    logic                irq_en_q;
    logic [CODE_W-1:0]   route_q;
    logic                load_pulse;
    logic                clr_pulse;
    logic [RELOAD_W-1:0] cnt_q;
    logic                expire;
    logic                pend_q;

    expiry_timer_regs #(
        .RELOAD_W (RELOAD_W),
        .ADDR_W   (ADDR_W),
        .CODE_W   (CODE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pend       (pend_q),
        .reload_q   (reload_q),
        .run_q      (run_q),
        .irq_en_q   (irq_en_q),
        .route_q    (route_q),
        .load_pulse (load_pulse),
        .clr_pulse  (clr_pulse)
    );

    expiry_timer_core #(
        .RELOAD_W (RELOAD_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .reload     (reload_q),
        .load_pulse (load_pulse),
        .clr_pulse  (clr_pulse),
        .cnt_q      (cnt_q),
        .expire     (expire),
        .pend_q     (pend_q)
    );

    expiry_timer_steer #(
        .NUM_CORES (NUM_CORES),
        .CODE_W    (CODE_W)
    ) u_steer (
        .pend     (pend_q),
        .irq_en   (irq_en_q),
        .route    (route_q),
        .core_irq (core_irq),
        .core_fiq (core_fiq)
    );
endmodule

// File: rtl/expiry_timer_chk.sv
// Module: checker for the expiry timer, bound into every instance.
// Watches internal state across the register file, counter and steering.
module expiry_timer_chk #(
    parameter int unsigned RELOAD_W  = 28,
    parameter int unsigned NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic                 irq_en,
    input logic [RELOAD_W-1:0]  reload,
    input logic [RELOAD_W-1:0]  cnt,
    input logic                 expire,
    input logic                 load_pulse,
    input logic                 clr_pulse,
    input logic                 pend,
    input logic [NUM_CORES-1:0] core_irq,
    input logic [NUM_CORES-1:0] core_fiq
);
    // R3: an expiry leaves the count holding the reload value and the flag set.
    p_reload_on_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(reload)) && pend);

    // R4: a stopped timer with no load keeps its count.
    p_frozen_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_pulse) |=> $stable(cnt));

    // R5: the flag only moves on an expiry or a clear.
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !clr_pulse) |=> $stable(pend));

    // R5: a clear without an expiry drops the flag.
    p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !expire) |=> !pend);

    // R6: an expiry beats a clear in the same clock.
    p_expiry_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && expire) |=> pend);

    // R7: no output while masked or not pending.
    p_quiet_when_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !pend) |-> ({core_fiq, core_irq} == '0));

    // R8: at most one destination at a time, and one when active.
    p_single_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_fiq, core_irq}) && ((irq_en && pend) == ({core_fiq, core_irq} != '0)));
endmodule

bind expiry_timer expiry_timer_chk #(
    .RELOAD_W  (RELOAD_W),
    .NUM_CORES (NUM_CORES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .irq_en     (irq_en_q),
    .reload     (reload_q),
    .cnt        (cnt_q),
    .expire     (expire),
    .load_pulse (load_pulse),
    .clr_pulse  (clr_pulse),
    .pend       (pend_q),
    .core_irq   (core_irq),
    .core_fiq   (core_fiq)
);

// File: tb/expiry_timer_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped once per clock and compared
// with the read data and all eight outputs after every edge.
module expiry_timer_bench;
    localparam logic [3:0]  A_CTRL = 4'h0;
    localparam logic [3:0]  A_ACT  = 4'h4;
    localparam logic [3:0]  A_RT   = 4'h8;
    localparam logic [3:0]  A_NONE = 4'hC;
    localparam logic [31:0] RUN    = 32'h1000_0000;
    localparam logic [31:0] IE     = 32'h2000_0000;
    localparam logic [31:0] LOAD   = 32'h4000_0000;
    localparam logic [31:0] CLR    = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_irq;
    logic [3:0]  core_fiq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    int unsigned m_reload = 0;
    bit          m_run = 0;
    bit          m_ie = 0;
    bit          m_pend = 0;
    int unsigned m_cnt = 0;
    int unsigned m_route = 0;

    always #2.5 clk = ~clk;

    expiry_timer u_expiry_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_irq  (core_irq),
        .core_fiq  (core_fiq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [31:0] rd;
        logic [31:0] outs;
        rd = '0;
        if (bus_addr == A_CTRL)
            rd = {m_pend, 1'b0, m_ie, m_run, m_reload[27:0]};
        else if (bus_addr == A_RT)
            rd = m_route;
        outs = '0;
        if (m_pend && m_ie) begin
            if (m_route < 4) outs[m_route] = 1'b1;
            else             outs[m_route] = 1'b1;  // fast lines sit at 4..7
        end
        check(tag, "rdata", bus_rdata, rd);
        check(tag, "outputs", {24'b0, core_fiq, core_irq}, outs);
    endtask

    // One bus cycle: drive, advance the model and the design, compare.
    task automatic step(input logic [3:0] a, input logic we,
                        input logic [31:0] d, input string tag);
        bit          exp_now;
        int unsigned cnt_n;
        bit          pend_n;
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = d;
        exp_now = m_run && (m_cnt <= 1);
        if (exp_now || (we && a == A_ACT && d[30])) cnt_n = m_reload;
        else if (m_run)                              cnt_n = m_cnt - 1;
        else                                         cnt_n = m_cnt;
        if (exp_now)                              pend_n = 1'b1;
        else if (we && a == A_ACT && d[31])       pend_n = 1'b0;
        else                                      pend_n = m_pend;
        @(posedge clk);
        @(negedge clk);
        m_cnt  = cnt_n;
        m_pend = pend_n;
        if (we && a == A_CTRL) begin
            m_reload = d[27:0];
            m_run    = d[28];
            m_ie     = d[29];
        end
        if (we && a == A_RT) m_route = d[2:0];
        bus_we = 1'b0;
        compare(tag);
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every readable word and output.
        compare("R1");
        step(A_RT, 1'b0, '0, "R1");
        step(A_ACT, 1'b0, '0, "R1");

        // R2: fields, read-only pending, bit 30, unmapped offsets.
        step(A_CTRL, 1'b1, 32'hC000_0005, "R2");
        step(A_CTRL, 1'b1, 32'h0ABC_DEF1, "R2");
        step(A_NONE, 1'b1, 32'hFFFF_FFFF, "R2");
        step(A_CTRL, 1'b0, '0, "R2");

        // R3: reload 5, restart the count, then run freely.
        step(A_CTRL, 1'b1, IE | 32'd5, "R3");
        step(A_ACT, 1'b1, LOAD, "R5");
        step(A_CTRL, 1'b1, RUN | IE | 32'd5, "R3");
        for (int i = 0; i < 14; i++) step(A_CTRL, 1'b0, '0, "R3");

        // R5: clear, ignored action bits, restart while running.
        step(A_ACT, 1'b1, CLR, "R5");
        step(A_ACT, 1'b1, 32'h3FFF_FFFF, "R5");
        step(A_CTRL, 1'b0, '0, "R5");
        step(A_ACT, 1'b1, LOAD, "R5");
        for (int i = 0; i < 8; i++) step(A_CTRL, 1'b0, '0, "R5");

        // R6: back-to-back clears; one lands on an expiry clock.
        for (int i = 0; i < 12; i++) step(A_ACT, 1'b1, CLR, "R6");
        step(A_CTRL, 1'b1, RUN | IE, "R3");
        for (int i = 0; i < 4; i++) step(A_ACT, 1'b1, CLR, "R6");
        step(A_CTRL, 1'b0, '0, "R6");

        // R7: masked enable with expiries, then unmask.
        step(A_CTRL, 1'b1, RUN | 32'd3, "R7");
        step(A_ACT, 1'b1, CLR, "R7");
        for (int i = 0; i < 8; i++) step(A_CTRL, 1'b0, '0, "R7");
        step(A_CTRL, 1'b1, RUN | IE | 32'd3, "R7");
        step(A_CTRL, 1'b0, '0, "R7");

        // R8 / R9: sweep every code with junk in the upper bits.
        for (int c = 0; c < 8; c++) begin
            step(A_RT, 1'b1, 32'hFFFF_FFF8 | c, "R9");
            step(A_RT, 1'b0, '0, "R8");
            step(A_CTRL, 1'b0, '0, "R8");
        end
        step(A_RT, 1'b1, 32'd2, "R9");

        // R4: stop, clear, wait, then resume from the frozen count.
        step(A_CTRL, 1'b1, IE | 32'd7, "R4");
        step(A_ACT, 1'b1, CLR, "R4");
        for (int i = 0; i < 30; i++) step(A_CTRL, 1'b0, '0, "R4");
        step(A_CTRL, 1'b1, RUN | IE | 32'd7, "R4");
        for (int i = 0; i < 12; i++) step(A_CTRL, 1'b0, '0, "R4");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule